// File: doc/BRIEF.md
# Read Delay Window Calibration Engine

This block trains the read-capture delay setting of a DDR memory interface without software help. After a start pulse it tries every delay code in turn, from zero upward. For each code it writes a fixed set of test words to memory and reads each word back several times. A code passes only if every read returns the expected word. The engine finds the contiguous passing window that begins at the first passing code and takes the centre of that window.

It runs the sweep twice: once at a first bank base address and once at a second. It then reports the floor-average of the two centres as the final delay code. A 32-bit timing word is also presented: a fixed upper pattern with the current delay code in its low bits. The memory controller can load this word directly. The physical layer and the controller itself sit outside this block. The engine talks to them through a plain word-wide request port: a write strobe, a read strobe, a byte address and write data go out; read data and a read-valid flag come back.

Top module: `rdwin_cal`

## Requirements
- R1: During a sweep the delay code under test starts at 0 and rises by one per trial, up to at most 2^CODE_W-1. `delay_code` shows the code under test while the engine is busy.
- R2: `timing_word` always equals 32'h80800800 OR the zero-extended `delay_code`.
- R3: Each trial writes WORDS test words before issuing any read. Word i goes to byte address base+4*i. Its value comes from a seed chosen by bits [5:4] of i (0: 32'h00000000, 1: 32'hAAAAAAAA, 2: 32'hA5A5A5A5, 3: 32'hAA55AA55). The word is the bitwise complement of that seed when bit 1 XOR bit 3 of i is 1.
- R4: Each word is read READS times in a row, in ascending word order. Only one read is outstanding, and the engine waits for `mem_rvalid` before comparing. The first mismatch ends the trial as failed, and no further read of that trial is issued.
- R5: The first code whose trial passes becomes the window start. It is latched only once per sweep.
- R6: Failing trials before the first pass are ignored. The first failing trial after a pass sets the window end to that code minus one and ends the sweep.
- R7: If no failure follows the first pass, the window end is the top code 2^CODE_W-1.
- R8: A bank result is floor((window start + window end) / 2).
- R9: The sweep runs first at base 32'h00000000 and then at base 32'h08000000. The final code is the floor-average of the two bank results.
- R10: `err` is set together with `done` when either bank had no passing code, and is cleared at the next accepted start. The final code is then unspecified.
- R11: `start` is ignored while a calibration is running.
- R12: `done` is high for exactly one cycle. After it, `delay_code` holds the final code until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a calibration (taken only when idle) |
| done | output | 1 | One-cycle pulse when calibration finishes |
| err | output | 1 | A bank had no passing code (valid from done) |
| mem_wr | output | 1 | Write request strobe |
| mem_rd | output | 1 | Read request strobe |
| mem_addr | output | ADDR_W | Byte address of the request |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read return data |
| mem_rvalid | input | 1 | Read return valid |
| delay_code | output | CODE_W | Code under test while busy, final code when idle |
| timing_word | output | 32 | Composed timing-register word |

## Verification
The bench builds the engine with CODE_W=4 and READS=2, and keeps WORDS at its full 64. A sixteen-code space lets each run complete both full sweeps in a few thousand cycles. That brings within reach a window that runs to the top code, a bank with no passing code, and an isolated passing code followed by a later window. Keeping all 64 words exercises every seed group and complement position of the test pattern. READS=2 is enough to show that a corruption on the last repeat of a word is caught.

// File: rtl/rdwin_pkg.sv
package rdwin_pkg;

  localparam int DW = 32;

  typedef enum logic [1:0] {TR_IDLE, TR_WRITE, TR_RD_REQ, TR_RD_WAIT} trial_st_e;
  typedef enum logic [1:0] {SW_IDLE, SW_LAUNCH, SW_RUN} sweep_st_e;
  typedef enum logic [1:0] {CAL_IDLE, CAL_BANK0, CAL_BANK1} cal_st_e;

  // Test word for a given index: seed from bits [5:4], inverted on bit1^bit3.
  function automatic logic [DW-1:0] pattern_word(input int unsigned idx);
    logic [DW-1:0] seed;
    case ((idx >> 4) & 32'd3)
      32'd0:   seed = 32'h0000_0000;
      32'd1:   seed = 32'hAAAA_AAAA;
      32'd2:   seed = 32'hA5A5_A5A5;
      default: seed = 32'hAA55_AA55;
    endcase
    if ((((idx >> 1) ^ (idx >> 3)) & 32'd1) != 32'd0) return ~seed;
    return seed;
  endfunction

  // Floor of the average of two codes.
  function automatic int unsigned floor_mid(input int unsigned a, input int unsigned b);
    return (a + b) >> 1;
  endfunction

endpackage

// File: rtl/rdwin_trial.sv
module rdwin_trial
  import rdwin_pkg::*;
#(
  parameter int WORDS  = 64,
  parameter int READS  = 10,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] base,
  output logic              mem_wr,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  input  logic              mem_rvalid,
  output logic              fin,
  output logic              pass
);

  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int REP_W = (READS > 1) ? $clog2(READS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);
  localparam logic [REP_W-1:0] LAST_REP = REP_W'(READS - 1);

  trial_st_e        st;
  logic [IDX_W-1:0] idx;
  logic [REP_W-1:0] rep;

  logic [DW-1:0] expect_w;
  logic          resp_ok, miscmp, word_done, all_done;

  assign expect_w  = pattern_word(32'(idx));
  assign resp_ok   = (st == TR_RD_WAIT) && mem_rvalid && (mem_rdata == expect_w);
  assign miscmp    = (st == TR_RD_WAIT) && mem_rvalid && (mem_rdata != expect_w);
  assign word_done = resp_ok && (rep == LAST_REP);
  assign all_done  = word_done && (idx == LAST_IDX);

  assign mem_wr    = (st == TR_WRITE);
  assign mem_rd    = (st == TR_RD_REQ);
  assign mem_addr  = base + ADDR_W'({idx, 2'b00});
  assign mem_wdata = expect_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= TR_IDLE;
      idx  <= '0;
      rep  <= '0;
      fin  <= 1'b0;
      pass <= 1'b0;
    end else begin
      fin  <= 1'b0;
      pass <= 1'b0;
      case (st)
        TR_IDLE: if (go) begin
          idx <= '0;
          st  <= TR_WRITE;
        end
        TR_WRITE: begin
          if (idx == LAST_IDX) begin
            idx <= '0;
            rep <= '0;
            st  <= TR_RD_REQ;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        TR_RD_REQ: st <= TR_RD_WAIT;
        TR_RD_WAIT: begin
          if (miscmp) begin
            fin <= 1'b1;
            st  <= TR_IDLE;
          end else if (all_done) begin
            fin  <= 1'b1;
            pass <= 1'b1;
            st   <= TR_IDLE;
          end else if (word_done) begin
            idx <= idx + 1'b1;
            rep <= '0;
            st  <= TR_RD_REQ;
          end else if (resp_ok) begin
            rep <= rep + 1'b1;
            st  <= TR_RD_REQ;
          end
        end
        default: st <= TR_IDLE;
      endcase
    end
  end

  AST_MISMATCH_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    miscmp |=> (fin && !pass && !mem_rd && !mem_wr)); // R4

  AST_READ_WAITS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (st == TR_RD_WAIT && !mem_rvalid) |=> (st == TR_RD_WAIT && !mem_rd)); // R4

endmodule

// File: rtl/rdwin_sweep.sv
module rdwin_sweep
  import rdwin_pkg::*;
#(
  parameter int CODE_W = 9,
  parameter int WORDS  = 64,
  parameter int READS  = 10,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] base,
  output logic              mem_wr,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  input  logic              mem_rvalid,
  output logic [CODE_W-1:0] code,
  output logic              sw_done,
  output logic              found,
  output logic [CODE_W-1:0] result
);

  localparam logic [CODE_W-1:0] MAX_CODE = '1;

  sweep_st_e         st;
  logic [CODE_W-1:0] code_q, first_q, last_q;
  logic              have_first;

  logic t_go, t_fin, t_pass;
  logic pass_evt, fail_evt, close_evt, at_top;

  assign t_go = (st == SW_LAUNCH);

  rdwin_trial #(.WORDS(WORDS), .READS(READS), .ADDR_W(ADDR_W)) u_trial (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (t_go),
    .base       (base),
    .mem_wr     (mem_wr),
    .mem_rd     (mem_rd),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .mem_rvalid (mem_rvalid),
    .fin        (t_fin),
    .pass       (t_pass)
  );

  assign pass_evt  = (st == SW_RUN) && t_fin && t_pass;
  assign fail_evt  = (st == SW_RUN) && t_fin && !t_pass;
  assign close_evt = fail_evt && have_first;
  assign at_top    = (code_q == MAX_CODE);

  assign code   = code_q;
  assign result = CODE_W'(floor_mid(32'(first_q), 32'(last_q)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= SW_IDLE;
      code_q     <= '0;
      first_q    <= '0;
      last_q     <= MAX_CODE;
      have_first <= 1'b0;
      found      <= 1'b0;
      sw_done    <= 1'b0;
    end else begin
      sw_done <= 1'b0;
      case (st)
        SW_IDLE: if (go) begin
          code_q     <= '0;
          first_q    <= '0;
          last_q     <= MAX_CODE;
          have_first <= 1'b0;
          found      <= 1'b0;
          st         <= SW_LAUNCH;
        end
        SW_LAUNCH: st <= SW_RUN;
        SW_RUN: begin
          if (pass_evt) begin
            if (!have_first) begin
              first_q    <= code_q;
              have_first <= 1'b1;
            end
            if (at_top) begin
              sw_done <= 1'b1;
              found   <= 1'b1;
              st      <= SW_IDLE;
            end else begin
              code_q <= code_q + 1'b1;
              st     <= SW_LAUNCH;
            end
          end else if (fail_evt) begin
            if (have_first) begin
              last_q  <= code_q - 1'b1;
              sw_done <= 1'b1;
              found   <= 1'b1;
              st      <= SW_IDLE;
            end else if (at_top) begin
              sw_done <= 1'b1;
              found   <= 1'b0;
              st      <= SW_IDLE;
            end else begin
              code_q <= code_q + 1'b1;
              st     <= SW_LAUNCH;
            end
          end
        end
        default: st <= SW_IDLE;
      endcase
    end
  end

  AST_CODE_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q != $past(code_q)) |-> (code_q == $past(code_q) + 1'b1 || code_q == '0)); // R1

  AST_START_LATCHED_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (have_first && $past(have_first)) |-> $stable(first_q)); // R5

  AST_CLOSE_STOPS_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
    close_evt |=> (sw_done && st == SW_IDLE && last_q == $past(code_q) - 1'b1)); // R6

endmodule

// File: rtl/rdwin_cal.sv
module rdwin_cal
  import rdwin_pkg::*;
#(
  parameter int                CODE_W     = 9,
  parameter int                WORDS      = 64,
  parameter int                READS      = 10,
  parameter int                ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] BANK0_BASE = 32'h0000_0000,
  parameter logic [ADDR_W-1:0] BANK1_BASE = 32'h0800_0000,
  parameter logic [DW-1:0]     TR_BASE    = 32'h8080_0800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              done,
  output logic              err,
  output logic              mem_wr,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  input  logic              mem_rvalid,
  output logic [CODE_W-1:0] delay_code,
  output logic [DW-1:0]     timing_word
);

  cal_st_e           st;
  logic              sw_go, found0, busy;
  logic [CODE_W-1:0] res0, final_q;
  logic [ADDR_W-1:0] bank_base;

  logic              sw_done, sw_found;
  logic [CODE_W-1:0] sw_code, sw_res;

  assign busy      = (st != CAL_IDLE);
  assign bank_base = (st == CAL_BANK1) ? BANK1_BASE : BANK0_BASE;

  rdwin_sweep #(.CODE_W(CODE_W), .WORDS(WORDS), .READS(READS), .ADDR_W(ADDR_W)) u_sweep (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (sw_go),
    .base       (bank_base),
    .mem_wr     (mem_wr),
    .mem_rd     (mem_rd),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .mem_rvalid (mem_rvalid),
    .code       (sw_code),
    .sw_done    (sw_done),
    .found      (sw_found),
    .result     (sw_res)
  );

  assign delay_code  = busy ? sw_code : final_q;
  assign timing_word = TR_BASE | DW'(delay_code);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= CAL_IDLE;
      sw_go   <= 1'b0;
      res0    <= '0;
      found0  <= 1'b0;
      final_q <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      sw_go <= 1'b0;
      done  <= 1'b0;
      case (st)
        CAL_IDLE: if (start) begin
          err   <= 1'b0;
          sw_go <= 1'b1;
          st    <= CAL_BANK0;
        end
        CAL_BANK0: if (sw_done) begin
          res0   <= sw_res;
          found0 <= sw_found;
          sw_go  <= 1'b1;
          st     <= CAL_BANK1;
        end
        CAL_BANK1: if (sw_done) begin
          final_q <= CODE_W'(floor_mid(32'(res0), 32'(sw_res)));
          err     <= !(found0 && sw_found);
          done    <= 1'b1;
          st      <= CAL_IDLE;
        end
        default: st <= CAL_IDLE;
      endcase
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R12

  AST_CODE_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(delay_code)); // R12

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !sw_done) |=> !sw_go); // R11

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done); // R10

endmodule

// File: tb/sim_rdwin_cal.sv
module sim_rdwin_cal;

  localparam int CW       = 4;
  localparam int NW       = 64;
  localparam int NR       = 2;
  localparam int NCODE    = 1 << CW;
  localparam int BAD_WORD = 37;
  localparam int LAT      = 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          done, err, mem_wr, mem_rd;
  logic [31:0]   mem_addr, mem_wdata;
  logic [31:0]   mem_rdata = '0;
  logic          mem_rvalid = 1'b0;
  logic [CW-1:0] delay_code;
  logic [31:0]   timing_word;

  always #5 clk = ~clk;

  rdwin_cal #(.CODE_W(CW), .WORDS(NW), .READS(NR)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .err(err),
    .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
    .delay_code(delay_code), .timing_word(timing_word)
  );

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Test word restated: seed group by index/16, inverted on alternate pairs,
  // with the inversion sense flipped in the second half of each group of 16.
  function automatic logic [31:0] bench_pat(input int i);
    logic [31:0] seeds [4];
    bit inv;
    seeds[0] = 32'h0000_0000; seeds[1] = 32'hAAAA_AAAA;
    seeds[2] = 32'hA5A5_A5A5; seeds[3] = 32'hAA55_AA55;
    inv = ((i % 4) >= 2) != ((i % 16) >= 8);
    return inv ? ~seeds[(i / 16) % 4] : seeds[(i / 16) % 4];
  endfunction

  // Memory model state
  logic [15:0] mask [2];
  logic [31:0] mem [2][NW];
  int  wr_cnt [2];
  int  rd_cnt [2];
  int  pat_err, order_err, tw_err, seq_err, done_cnt;
  int  snap_b0;
  bit  snap_taken, rd_seen, pend;
  int  last_word, rep, pend_dly, last_rd_code, prev_code;
  logic [31:0] pend_data;

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_rvalid = 1'b0;
      pend = 1'b0;
    end else begin
      mem_rvalid = 1'b0;
      if (pend) begin
        if (pend_dly == 0) begin
          mem_rvalid = 1'b1;
          mem_rdata  = pend_data;
          pend       = 1'b0;
        end else begin
          pend_dly--;
        end
      end
      if (done) done_cnt++;
      if (int'(delay_code) != prev_code) rd_seen = 1'b0;
      prev_code = int'(delay_code);
      if (mem_wr) begin
        if (mem_wdata !== bench_pat(int'(mem_addr[7:2])) || (mem_addr & ~32'h0800_00FC) != 0)
          pat_err++;
        if (rd_seen) order_err++;
        if (mem_addr[27] && !snap_taken) begin
          snap_taken = 1'b1;
          snap_b0    = wr_cnt[0];
        end
        mem[mem_addr[27]][mem_addr[7:2]] = mem_wdata;
        wr_cnt[mem_addr[27]]++;
        last_word = -1;
      end
      if (mem_rd) begin
        automatic int  c = int'(delay_code);
        automatic int  w = int'(mem_addr[7:2]);
        automatic bit  b = mem_addr[27];
        automatic logic [31:0] d;
        if (timing_word !== (32'h8080_0800 | {28'd0, delay_code})) tw_err++;
        if (last_rd_code >= 0 && c != last_rd_code && c != last_rd_code + 1 && c != 0) seq_err++;
        last_rd_code = c;
        if (w == last_word) rep++;
        else begin rep = 0; last_word = w; end
        rd_seen = 1'b1;
        d = mem[b][w];
        if (!mask[b][c] && w == BAD_WORD && rep == NR - 1) d = d ^ 32'h0000_0100;
        pend      = 1'b1;
        pend_dly  = LAT;
        pend_data = d;
        rd_cnt[b]++;
      end
    end
  end

  function automatic void bank_expect(input logic [15:0] m, output int res, output bit found,
                                      output int writes, output int reads);
    int first, last, trials, passes;
    first = 0; last = NCODE - 1; trials = 0; passes = 0; found = 0;
    for (int c = 0; c < NCODE; c++) begin
      trials++;
      if (m[c]) begin
        passes++;
        if (!found) begin found = 1; first = c; end
      end else if (found) begin
        last = c - 1;
        break;
      end
    end
    res    = (first + last) / 2;
    writes = trials * NW;
    reads  = passes * NW * NR + (trials - passes) * (BAD_WORD + 1) * NR;
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0, "R12", "reset done", 64'(done), 0);
    chk(err == 1'b0, "R10", "reset err", 64'(err), 0);
    chk(!mem_wr && !mem_rd, "R4", "reset no requests", 64'({mem_wr, mem_rd}), 0);
    chk(delay_code == '0, "R12", "reset code", 64'(delay_code), 0);
    chk(timing_word == 32'h8080_0800, "R2", "reset timing word", 64'(timing_word), 64'h8080_0800);
  endtask

  task automatic t_run(input string name, input logic [15:0] m0, input logic [15:0] m1,
                       input bit poke);
    int r0, r1, w0, w1, rd0, rd1, n;
    bit f0, f1;
    logic [CW-1:0] held;
    @(posedge clk);
    mask[0] = m0; mask[1] = m1;
    wr_cnt[0] = 0; wr_cnt[1] = 0; rd_cnt[0] = 0; rd_cnt[1] = 0;
    pat_err = 0; order_err = 0; tw_err = 0; seq_err = 0; done_cnt = 0;
    snap_taken = 0; snap_b0 = -1; rd_seen = 0; last_word = -1; last_rd_code = -1;
    bank_expect(m0, r0, f0, w0, rd0);
    bank_expect(m1, r1, f1, w1, rd1);
    #1 start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    if (poke) begin
      repeat (300) @(posedge clk);
      #1 start = 1'b1;
      @(posedge clk);
      #1 start = 1'b0;
    end
    n = 0;
    while (!done && n < 60000) begin
      @(negedge clk);
      n++;
    end
    chk(done == 1'b1, "R12", {name, " done seen"}, 64'(done), 1);
    chk(err == !(f0 && f1), "R10", {name, " err flag"}, 64'(err), 64'(!(f0 && f1)));
    if (f0 && f1) begin
      chk(int'(delay_code) == (r0 + r1) / 2, "R8 R9", {name, " final code"},
          64'(delay_code), 64'((r0 + r1) / 2));
      chk(timing_word == (32'h8080_0800 | 32'((r0 + r1) / 2)), "R2", {name, " final timing word"},
          64'(timing_word), 64'(32'h8080_0800 | 32'((r0 + r1) / 2)));
    end
    held = delay_code;
    @(negedge clk);
    chk(done == 1'b0, "R12", {name, " done one cycle"}, 64'(done), 0);
    repeat (6) @(negedge clk);
    chk(delay_code == held, "R12", {name, " code held"}, 64'(delay_code), 64'(held));
    chk(done_cnt == 1, "R11", {name, " done count"}, 64'(done_cnt), 1);
    chk(wr_cnt[0] == w0 && wr_cnt[1] == w1, "R1 R6", {name, " write totals"},
        64'({wr_cnt[0], wr_cnt[1]}), 64'({w0, w1}));
    chk(rd_cnt[0] == rd0 && rd_cnt[1] == rd1, "R4", {name, " read totals"},
        64'({rd_cnt[0], rd_cnt[1]}), 64'({rd0, rd1}));
    chk(snap_b0 == w0, "R9", {name, " bank0 finished before bank1"}, 64'(snap_b0), 64'(w0));
    chk(pat_err == 0, "R3", {name, " pattern and address"}, 64'(pat_err), 0);
    chk(order_err == 0, "R3", {name, " writes before reads"}, 64'(order_err), 0);
    chk(tw_err == 0, "R2", {name, " timing word in sweep"}, 64'(tw_err), 0);
    chk(seq_err == 0, "R1", {name, " code order"}, 64'(seq_err), 0);
  endtask

  initial begin
    #(10 * 190000);
    if (!ended) begin
      ended = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    // R5 R8 R9: plain windows 3..9 and 5..12 -> 6 and 8 -> 7
    t_run("windows", 16'h03F8, 16'h1FE0, 1'b0);
    // R6 R7: isolated pass at 4 then fail -> 4; window to top 10..15 -> 12 -> 8
    t_run("island_top", 16'h01D0, 16'hFC00, 1'b0);
    // R8 R7: 4..9 -> 6 (floor), all pass -> 7, final floor 6
    t_run("floor", 16'h03F0, 16'hFFFF, 1'b0);
    // R10: bank1 never passes
    t_run("no_pass", 16'h03F8, 16'h0000, 1'b0);
    // R11: start pulsed again mid-run
    t_run("busy_start", 16'h03F8, 16'h1FE0, 1'b1);
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule